// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 16-bit control words from a three-wire serial link made up of a select line, a serial clock and one data line. While select is high, it watches the data line for a fixed wake-up pattern. Once that pattern has been seen, it frames each following group of 16 serial-clock rising edges as one word. The first bit to arrive is the least significant bit.

The low 12 bits of each word are a data field. The top 4 bits are a command code. The code is decoded into single-cycle strobes: one for each of five register-write targets and one for each of four memory operations. The data field and the last accepted command code are held on outputs alongside the strobes.

All three serial inputs are resynchronised to the system clock and the serial-clock edges are detected by oversampling. The downstream logic therefore sees ordinary synchronous pulses. A reserved code raises an illegal-command pulse. Several other codes are accepted as no-operations.

Top module: `scw_receiver`

## Requirements
- R1: While select is high, no word is framed until the wake-up pattern has arrived on the data line. The default pattern is the eight bits 1,0,1,0,0,1,1,0 in arrival order. Words sent before that produce no strobe and leave `data_out` and `cmd_hold` unchanged.
- R2: Data is sampled on the rising edge of the serial clock. A word completes after exactly 16 edges, and the first bit received is bit 0. Bits 0 to 11 form the data field and bits 12 to 15 form the command code.
- R3: Code 1h pulses `mem_erase`, 2h pulses `mem_wr_begin`, 3h pulses `mem_read` and 5h pulses `mem_wr_end`.
- R4: Code 8h pulses `reg_wr[0]` (configuration). Codes 9h, Ah, Bh and Ch pulse `reg_wr[1]` to `reg_wr[4]` (offset trim, offset drift trim, span trim, span drift trim).
- R5: Codes 0h, 6h, 7h, Dh, Eh and Fh raise no strobe. They still load `data_out` and `cmd_hold` like any other completed word.
- R6: Code 4h is reserved. It raises `illegal_cmd` for one cycle and changes neither `data_out` nor `cmd_hold`.
- R7: Each strobe lasts one system-clock cycle. A word raises at most one strobe in total.
- R8: `data_out` and `cmd_hold` take the new word's fields in the same cycle its strobe rises. They hold those values until the next completed word.
- R9: Dropping select clears the bit count and the wake-up state. A partial word is discarded, serial-clock edges are ignored while select is low, and a new wake-up pattern is needed after select returns high.
- R10: After reset, every strobe is low and `data_out` and `cmd_hold` are zero.
- R11: After one wake-up pattern, any number of words can follow back to back without repeating the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select, active high |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| din | input | 1 | Serial data line |
| reg_wr | output | 5 | One-cycle register-write strobes, index 0 is configuration |
| mem_erase | output | 1 | One-cycle memory erase strobe |
| mem_wr_begin | output | 1 | One-cycle begin-write-at-address strobe |
| mem_read | output | 1 | One-cycle read-at-address strobe |
| mem_wr_end | output | 1 | One-cycle end-write-at-address strobe |
| illegal_cmd | output | 1 | One-cycle flag for the reserved code |
| data_out | output | 12 | Data field of the last accepted word |
| cmd_hold | output | 4 | Command code of the last accepted word |

## Verification
The assertions assume that each serial-clock level lasts longer than the synchronizer depth plus one system cycle. Under that assumption, no two completed words can land within two system cycles of each other. They also assume that select is not dropped within a few cycles of the last edge of a word. The stimulus holds every serial-clock phase for four system cycles and lets a word settle for twelve cycles before select changes. Random words, random codes and random deselect-and-rewake events are all generated inside that timing envelope.

// File: rtl/scw_pkg.sv
package scw_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] CODE_ERASE    = 4'h1;
   localparam logic [CODE_W-1:0] CODE_WR_BEGIN = 4'h2;
   localparam logic [CODE_W-1:0] CODE_READ     = 4'h3;
   localparam logic [CODE_W-1:0] CODE_RESERVED = 4'h4;
   localparam logic [CODE_W-1:0] CODE_WR_END   = 4'h5;

   typedef struct packed {
      logic erase;
      logic wr_begin;
      logic rd;
      logic wr_end;
   } mem_op_t;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_HUNT  = 2'd1,
      FR_WORD  = 2'd2
   } frame_state_t;

endpackage

// File: rtl/scw_input_sync.sv
module scw_input_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("scw_input_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe_q;

         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) pipe_q[s] <= '0;
                  else        pipe_q[s] <= d_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) pipe_q[s] <= '0;
                  else        pipe_q[s] <= pipe_q[s-1];
               end
            end
         end

         assign d_out = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scw_framer.sv
module scw_framer
   import scw_pkg::*;
#(
   parameter int                  WORD_W       = 16,
   parameter int                  INIT_LEN     = 8,
   parameter logic [INIT_LEN-1:0] INIT_PATTERN = 8'hA6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_q,
   input  logic              sclk_q,
   input  logic              din_q,
   output logic              word_done,
   output logic [WORD_W-1:0] word_q
);

   localparam int CNT_W    = $clog2(WORD_W);
   localparam int LAST_BIT = WORD_W - 1;

   frame_state_t        state_q;
   logic                sclk_prev_q;
   logic                rise;
   logic [INIT_LEN-1:0] hist_q;
   logic [INIT_LEN-1:0] hist_next;
   logic [CNT_W-1:0]    cnt_q;
   logic [WORD_W-1:0]   shift_q;
   logic [WORD_W-1:0]   shift_next;

   assign rise       = sclk_q & ~sclk_prev_q;
   assign hist_next  = {hist_q[INIT_LEN-2:0], din_q};
   assign shift_next = {din_q, shift_q[WORD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev_q <= 1'b0;
      else        sclk_prev_q <= sclk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= FR_IDLE;
         hist_q    <= '0;
         cnt_q     <= '0;
         shift_q   <= '0;
         word_q    <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (!cs_q) begin
            state_q <= FR_IDLE;
            hist_q  <= '0;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               FR_IDLE: begin
                  state_q <= FR_HUNT;
                  hist_q  <= '0;
                  cnt_q   <= '0;
                  if (rise) begin
                     hist_q <= hist_next;
                  end
               end
               FR_HUNT: begin
                  if (rise) begin
                     hist_q <= hist_next;
                     if (hist_next == INIT_PATTERN) begin
                        state_q <= FR_WORD;
                        cnt_q   <= '0;
                     end
                  end
               end
               FR_WORD: begin
                  if (rise) begin
                     shift_q <= shift_next;
                     if (cnt_q == CNT_W'(LAST_BIT)) begin
                        cnt_q     <= '0;
                        word_q    <= shift_next;
                        word_done <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: state_q <= FR_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/scw_decoder.sv
module scw_decoder
   import scw_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CMD_W    = 4,
   parameter int NUM_REGS = 5,
   parameter int REG_BASE = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      word_done,
   input  logic [DATA_W+CMD_W-1:0]   word_q,
   output logic [NUM_REGS-1:0]       reg_wr,
   output mem_op_t                   mem_op,
   output logic                      illegal_cmd,
   output logic [DATA_W-1:0]         data_out,
   output logic [CMD_W-1:0]          cmd_hold
);

   localparam int WORD_W = DATA_W + CMD_W;

   logic [CMD_W-1:0]    code;
   logic [DATA_W-1:0]   field;
   logic [NUM_REGS-1:0] reg_hit;
   mem_op_t             mem_hit;
   logic                rsv_hit;

   assign code  = word_q[WORD_W-1 -: CMD_W];
   assign field = word_q[DATA_W-1:0];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_hit
         assign reg_hit[i] = (code == CMD_W'(REG_BASE + i));
      end
   endgenerate

   always_comb begin
      mem_hit          = '0;
      mem_hit.erase    = (code == CODE_ERASE);
      mem_hit.wr_begin = (code == CODE_WR_BEGIN);
      mem_hit.rd       = (code == CODE_READ);
      mem_hit.wr_end   = (code == CODE_WR_END);
      rsv_hit          = (code == CODE_RESERVED);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr      <= '0;
         mem_op      <= '0;
         illegal_cmd <= 1'b0;
         data_out    <= '0;
         cmd_hold    <= '0;
      end else begin
         reg_wr      <= '0;
         mem_op      <= '0;
         illegal_cmd <= 1'b0;
         if (word_done) begin
            if (rsv_hit) begin
               illegal_cmd <= 1'b1;
            end else begin
               reg_wr   <= reg_hit;
               mem_op   <= mem_hit;
               data_out <= field;
               cmd_hold <= code;
            end
         end
      end
   end

endmodule

// File: rtl/scw_receiver.sv
module scw_receiver
   import scw_pkg::*;
#(
   parameter int                  DATA_W       = 12,
   parameter int                  CMD_W        = 4,
   parameter int                  NUM_REGS     = 5,
   parameter int                  REG_BASE     = 8,
   parameter int                  SYNC_STAGES  = 2,
   parameter int                  INIT_LEN     = 8,
   parameter logic [INIT_LEN-1:0] INIT_PATTERN = 8'hA6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs,
   input  logic                sclk,
   input  logic                din,
   output logic [NUM_REGS-1:0] reg_wr,
   output logic                mem_erase,
   output logic                mem_wr_begin,
   output logic                mem_read,
   output logic                mem_wr_end,
   output logic                illegal_cmd,
   output logic [DATA_W-1:0]   data_out,
   output logic [CMD_W-1:0]    cmd_hold
);

   localparam int WORD_W = DATA_W + CMD_W;

   generate
      if (CMD_W != CODE_W) begin : g_chk_cmd
         $error("scw_receiver: CMD_W must equal the 4-bit code map");
      end
      if (REG_BASE + NUM_REGS > (1 << CMD_W)) begin : g_chk_regs
         $error("scw_receiver: register codes overflow the code space");
      end
      if (REG_BASE <= 5) begin : g_chk_overlap
         $error("scw_receiver: register codes overlap memory codes");
      end
      if (INIT_LEN < 2) begin : g_chk_len
         $error("scw_receiver: INIT_LEN must be at least 2");
      end
      if (INIT_PATTERN[INIT_LEN-1] != 1'b1) begin : g_chk_pat
         $error("scw_receiver: first wake-up bit must be 1");
      end
   endgenerate

   logic [2:0]        raw_in;
   logic [2:0]        sync_out;
   logic              cs_q;
   logic              sclk_q;
   logic              din_q;
   logic              word_done;
   logic [WORD_W-1:0] word_q;
   mem_op_t           mem_op;

   assign raw_in = {cs, sclk, din};
   assign {cs_q, sclk_q, din_q} = sync_out;

   scw_input_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .d_out (sync_out)
   );

   scw_framer #(
      .WORD_W       (WORD_W),
      .INIT_LEN     (INIT_LEN),
      .INIT_PATTERN (INIT_PATTERN)
   ) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_q      (cs_q),
      .sclk_q    (sclk_q),
      .din_q     (din_q),
      .word_done (word_done),
      .word_q    (word_q)
   );

   scw_decoder #(
      .DATA_W   (DATA_W),
      .CMD_W    (CMD_W),
      .NUM_REGS (NUM_REGS),
      .REG_BASE (REG_BASE)
   ) u_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_done   (word_done),
      .word_q      (word_q),
      .reg_wr      (reg_wr),
      .mem_op      (mem_op),
      .illegal_cmd (illegal_cmd),
      .data_out    (data_out),
      .cmd_hold    (cmd_hold)
   );

   assign mem_erase    = mem_op.erase;
   assign mem_wr_begin = mem_op.wr_begin;
   assign mem_read     = mem_op.rd;
   assign mem_wr_end   = mem_op.wr_end;

endmodule

// File: rtl/scw_receiver_chk.sv
module scw_receiver_chk #(
   parameter int DATA_W   = 12,
   parameter int CMD_W    = 4,
   parameter int NUM_REGS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_q,
   input logic                word_done,
   input logic [NUM_REGS-1:0] reg_wr,
   input logic                mem_erase,
   input logic                mem_wr_begin,
   input logic                mem_read,
   input logic                mem_wr_end,
   input logic                illegal_cmd,
   input logic [DATA_W-1:0]   data_out,
   input logic [CMD_W-1:0]    cmd_hold
);

   logic [NUM_REGS+4:0] all_strobes;
   assign all_strobes = {illegal_cmd, mem_wr_end, mem_read, mem_wr_begin, mem_erase, reg_wr};

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(all_strobes));

   // R7
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|all_strobes) |=> !(|all_strobes));

   // R8
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |=> ($stable(data_out) && $stable(cmd_hold)));

   // R6
   reserved_no_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_cmd |-> ($stable(data_out) && $stable(cmd_hold)));

   // R9
   deselect_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q |=> !word_done);

   // R3
   erase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_erase |-> (cmd_hold == 4'h1));

   // R4
   cfg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr[0] |-> (cmd_hold == 4'h8));

endmodule

bind scw_receiver scw_receiver_chk #(
   .DATA_W   (DATA_W),
   .CMD_W    (CMD_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_q         (cs_q),
   .word_done    (word_done),
   .reg_wr       (reg_wr),
   .mem_erase    (mem_erase),
   .mem_wr_begin (mem_wr_begin),
   .mem_read     (mem_read),
   .mem_wr_end   (mem_wr_end),
   .illegal_cmd  (illegal_cmd),
   .data_out     (data_out),
   .cmd_hold     (cmd_hold)
);

// File: tb/scw_receiver_test.sv
module scw_receiver_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        sclk = 1'b0;
   logic        din = 1'b0;
   logic [4:0]  reg_wr;
   logic        mem_erase, mem_wr_begin, mem_read, mem_wr_end, illegal_cmd;
   logic [11:0] data_out;
   logic [3:0]  cmd_hold;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [11:0] m_data = '0;
   logic [3:0]  m_cmd  = '0;

   int          pulses;
   int          strobe_cycles;
   logic [9:0]  seen;

   always #2.5 clk = ~clk;

   scw_receiver uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
      .reg_wr(reg_wr), .mem_erase(mem_erase), .mem_wr_begin(mem_wr_begin),
      .mem_read(mem_read), .mem_wr_end(mem_wr_end), .illegal_cmd(illegal_cmd),
      .data_out(data_out), .cmd_hold(cmd_hold)
   );

   function automatic logic [9:0] cur_vec();
      return {illegal_cmd, mem_wr_end, mem_read, mem_wr_begin, mem_erase, reg_wr};
   endfunction

   function automatic logic [9:0] exp_vec(input logic [3:0] c);
      logic [9:0] v = '0;
      case (c)
         4'h1: v[5] = 1'b1;
         4'h2: v[6] = 1'b1;
         4'h3: v[7] = 1'b1;
         4'h5: v[8] = 1'b1;
         4'h4: v[9] = 1'b1;
         4'h8, 4'h9, 4'hA, 4'hB, 4'hC: v[c - 4'h8] = 1'b1;
         default: v = '0;
      endcase
      return v;
   endfunction

   always @(negedge clk) begin
      if (rst_n && (|cur_vec())) begin
         strobe_cycles++;
         seen = seen | cur_vec();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      sclk = 1'b0;
      din  = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
      sclk = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic send_init();
      logic [7:0] p = 8'hA6;
      for (int i = 7; i >= 0; i--) send_bit(p[i]);
   endtask

   task automatic send_word(input logic [3:0] c, input logic [11:0] d);
      logic [15:0] w = {c, d};
      strobe_cycles = 0;
      seen = '0;
      for (int i = 0; i < 16; i++) send_bit(w[i]);
      settle();
   endtask

   task automatic deselect();
      @(negedge clk);
      cs = 1'b0;
      sclk = 1'b0;
      repeat (10) @(negedge clk);
      cs = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic check_word(input logic [3:0] c, input logic [11:0] d, input string req);
      logic [9:0] ev = exp_vec(c);
      if (c != 4'h4) begin
         m_data = d;
         m_cmd  = c;
      end
      check(seen == ev, req, int'(seen), int'(ev));
      check(strobe_cycles == ((ev != 0) ? 1 : 0), {req, " R7 pulse count"},
            strobe_cycles, (ev != 0) ? 1 : 0);
      check(data_out == m_data, {req, " R8 data"}, int'(data_out), int'(m_data));
      check(cmd_hold == m_cmd, {req, " R8 cmd"}, int'(cmd_hold), int'(m_cmd));
   endtask

   task automatic check_silent(input string req);
      check(strobe_cycles == 0, req, strobe_cycles, 0);
      check(data_out == m_data, {req, " data"}, int'(data_out), int'(m_data));
      check(cmd_hold == m_cmd, {req, " cmd"}, int'(cmd_hold), int'(m_cmd));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5C0D_1E55));
      strobe_cycles = 0;
      seen = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10 reset state
      check(cur_vec() == '0, "R10 strobes", int'(cur_vec()), 0);
      check(data_out == '0, "R10 data", int'(data_out), 0);
      check(cmd_hold == '0, "R10 cmd", int'(cmd_hold), 0);

      // R1 words before wake-up are ignored
      cs = 1'b1;
      repeat (6) @(negedge clk);
      send_word(4'h8, 12'hABC);
      check_silent("R1 before wake-up");
      send_word(4'h1, 12'h123);
      check_silent("R1 before wake-up 2");

      // R2 R3 R4 R5 R6 R11 every code after one wake-up, bit order via distinct data
      deselect();
      send_init();
      for (int c = 0; c < 16; c++) begin
         logic [11:0] d = 12'h801 ^ 12'(c * 12'h111);
         send_word(4'(c), d);
         check_word(4'(c), d, "R2/R3/R4/R5/R6/R11 code sweep");
      end

      // R6 reserved right after a data word keeps previous fields
      send_word(4'h9, 12'h5A5);
      check_word(4'h9, 12'h5A5, "R4 offset trim");
      send_word(4'h4, 12'hFFF);
      check_word(4'h4, 12'hFFF, "R6 reserved");

      // R9 partial word discarded, wake-up lost
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      deselect();
      send_word(4'hA, 12'h0F0);
      check_silent("R9 no word after deselect");

      // R9 edges while deselected are ignored
      @(negedge clk);
      cs = 1'b0;
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      settle();
      cs = 1'b1;
      repeat (6) @(negedge clk);
      send_init();
      send_word(4'hC, 12'h00F);
      check_word(4'hC, 12'h00F, "R9 rewake then word");

      // R2 bit order corner: single set bits
      send_word(4'h8, 12'h001);
      check_word(4'h8, 12'h001, "R2 lsb");
      send_word(4'h8, 12'h800);
      check_word(4'h8, 12'h800, "R2 msb of data");

      // random words, occasional deselect and rewake
      for (int k = 0; k < 40; k++) begin
         logic [3:0]  c = 4'($urandom_range(0, 15));
         logic [11:0] d = 12'($urandom);
         if ($urandom_range(0, 7) == 0) begin
            deselect();
            send_init();
         end
         send_word(c, d);
         check_word(c, d, "R3/R4/R5/R6 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule